// File: doc/BRIEF.md
# Row-Scanning Matrix Keypad Decoder

This block scans a three-by-three switch matrix and reports which digit, 1 to 9, is held down. It drives three active-low row lines and reads three column lines that idle high through pull-ups. At any moment exactly one row is pulled low. A pressed switch joins its row to its column, so that column reads low only while its own row is the active one. The scanner moves to the next row only when every column reads high. Once a pressed key is found, it parks on that row for as long as the key stays down.

The column lines are asynchronous to the scan clock, so they pass through a two-stage synchronizer first. The row pattern is delayed by the same two stages. Each synchronized column sample is therefore decoded against the row that was active when it was taken. The scanner stays on each row until that delayed copy has caught up with the live row, so a press is never credited to the wrong row.

The key value is purely a function of the delayed row pattern and the synchronized column pattern. It reads zero whenever no column is low, or when more than one column is low.

Top module: `keypad_scan`

## Requirements
- R1: While `rst` is high at a clock edge, the next state drives `row_n` = 3'b011 and `key` = 0.
- R2: After reset, `row_n` always has exactly one bit low.
- R3: With no key pressed, the active row advances in the fixed order 011 → 101 → 110 → 011. Bit 2 of `row_n` is row 1 (keys 1–3), bit 1 is row 2 (keys 4–6) and bit 0 is row 3 (keys 7–9).
- R4: While a held key pulls a column low, the scanner stops on that key's row and `row_n` stays constant until the key is released.
- R5: `key` is 0 whenever the synchronized columns read 3'b111, including within a few cycles after a key is released.
- R6: Column bit 2 low selects the first key of the active row, bit 1 the second and bit 0 the third. `key` is the binary value 3·(row index) + (column index) + 1, covering 1 to 9.
- R7: If two columns of the parked row are low at once, `key` is 0 and the scanner still holds that row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| col_n | input | 3 | Column lines, idle high, pulled low by a pressed key on the active row |
| row_n | output | 3 | Row drive, exactly one bit low |
| key | output | 4 | Binary digit of the pressed key, 0 when none |

## Verification
The bench models the switch matrix. Each column is driven combinationally from the live row and from the set of pressed keys, so a scanner that stalled on the wrong row, or decoded a fresh column sample against a stale row, would report a neighbour's digit. Every one of the nine keys is pressed in turn, with random hold times and random idle gaps. This catches a key map with swapped rows or columns, and a scanner that keeps moving while a key is down. Two keys pressed in the same row check that the output falls to zero and the row stays parked, rather than the block reporting one of the two digits. After each release the bench expects zero, and while idle it checks the row rotation order, so a scanner that skipped a row or reversed direction would be caught.

// File: rtl/keypad_scan.sv
module keypad_scan #(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int KW   = $clog2(ROWS*COLS+1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [COLS-1:0] col_n,
  output logic [ROWS-1:0] row_n,
  output logic [KW-1:0]   key
);
  localparam logic [ROWS-1:0] ROW_INIT = ~(ROWS'(1) << (ROWS-1));
  localparam logic [COLS-1:0] COL_IDLE = '1;

  logic [ROWS-1:0] row_q, row_d1, row_d2;
  logic [COLS-1:0] col_s1, col_s2;
  logic            legal, settled, idle;

  function automatic int zeros_r(input logic [ROWS-1:0] v);
    int n = 0;
    for (int i = 0; i < ROWS; i++) if (!v[i]) n++;
    return n;
  endfunction

  function automatic int zeros_c(input logic [COLS-1:0] v);
    int n = 0;
    for (int i = 0; i < COLS; i++) if (!v[i]) n++;
    return n;
  endfunction

  assign legal   = zeros_r(row_q) == 1;
  assign settled = (row_d1 == row_q) && (row_d2 == row_q);
  assign idle    = col_s2 == COL_IDLE;
  assign row_n   = row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= ROW_INIT;
      row_d1 <= ROW_INIT;
      row_d2 <= ROW_INIT;
      col_s1 <= COL_IDLE;
      col_s2 <= COL_IDLE;
    end else begin
      col_s1 <= col_n;
      col_s2 <= col_s1;
      row_d1 <= row_q;
      row_d2 <= row_d1;
      if (!legal)
        row_q <= ROW_INIT;
      else if (settled && idle)
        row_q <= {row_q[0], row_q[ROWS-1:1]};
    end
  end

  always_comb begin
    key = '0;
    if (zeros_r(row_d2) == 1 && zeros_c(col_s2) == 1)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          if (!row_d2[ROWS-1-r] && !col_s2[COLS-1-c])
            key = KW'(r*COLS + c + 1);
  end

  a_r1_reset_row: assert property (@(posedge clk)
    rst |=> (row_n == ROW_INIT && key == '0));

  a_r2_one_row_low: assert property (@(posedge clk) disable iff (rst)
    $countones(~row_n) == 1);

  a_r3_rotate_order: assert property (@(posedge clk) disable iff (rst)
    (row_n != $past(row_n)) |->
      (row_n == {$past(row_n[0]), $past(row_n[ROWS-1:1])}));

  a_r4_hold_on_press: assert property (@(posedge clk) disable iff (rst)
    (settled && !idle) |=> $stable(row_n));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    idle |-> key == '0);

  a_r6_key_range: assert property (@(posedge clk) disable iff (rst)
    key <= KW'(ROWS*COLS));

  a_r7_multi_zero: assert property (@(posedge clk) disable iff (rst)
    ($countones(~col_s2) > 1) |-> key == '0);
endmodule

// File: tb/test_keypad_scan.sv
module test_keypad_scan;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] col_n;
  logic [2:0] row_n;
  logic [3:0] key;
  logic [8:0] pressed = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keypad_scan i_keypad_scan (.clk(clk), .rst(rst), .col_n(col_n), .row_n(row_n), .key(key));

  always_comb begin
    col_n = 3'b111;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        if (pressed[r*3+c] && !row_n[2-r]) col_n[2-c] = 1'b0;
  end

  function automatic logic [2:0] row_pat(input int r);
    return ~(3'b100 >> r);
  endfunction

  function automatic logic [2:0] rot(input logic [2:0] v);
    return {v[0], v[2:1]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk)
    if (!rst && !done) check("R2 one row low", $countones(~row_n), 1);

  task automatic press_one(input int k, input int hold);
    logic [2:0] r0;
    pressed = 9'(1) << k;
    cyc(20);
    check("R6 key value", int'(key), k + 1);
    check("R4 parked row", int'(row_n), int'(row_pat(k / 3)));
    r0 = row_n;
    for (int i = 0; i < hold; i++) begin
      cyc(1);
      if (row_n != r0) check("R4 row held", int'(row_n), int'(r0));
    end
    check("R4 row held at end", int'(row_n), int'(r0));
    check("R6 key stable", int'(key), k + 1);
    pressed = '0;
    cyc(6);
    check("R5 zero after release", int'(key), 0);
  endtask

  initial begin
    int seed;
    logic [2:0] prev;
    seed = $urandom(32'h5eed1);
    cyc(3);
    check("R1 reset row", int'(row_n), 3'b011);
    check("R1 reset key", int'(key), 0);
    rst = 0;
    prev = row_n;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (row_n != prev) begin
        check("R3 rotation", int'(row_n), int'(rot(prev)));
        prev = row_n;
      end
      check("R5 idle key", int'(key), 0);
    end
    for (int k = 0; k < 9; k++) press_one(k, 10);
    for (int r = 0; r < 3; r++) begin
      pressed = (9'b011 << (r*3));
      cyc(20);
      check("R7 double key zero", int'(key), 0);
      check("R7 row held", int'(row_n), int'(row_pat(r)));
      cyc(10);
      check("R7 row still held", int'(row_n), int'(row_pat(r)));
      pressed = '0;
      cyc(6);
    end
    for (int i = 0; i < 30; i++) begin
      int k, g;
      k = int'($urandom % 9);
      g = int'($urandom % 16);
      press_one(k, 5 + int'($urandom % 30));
      for (int j = 0; j < g; j++) begin
        cyc(1);
        check("R5 gap key", int'(key), 0);
      end
    end
    rst = 1;
    cyc(2);
    check("R1 reset again row", int'(row_n), 3'b011);
    check("R1 reset again key", int'(key), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule